// File: doc/BRIEF.md
# Converter Serial Register Port

This block is the host-facing serial port of a sigma-delta converter. A host talks to it over a three-wire bus: an active-low select, a serial clock that idles high, and a data input. A shared data output carries read data during a transfer. Between transfers it carries an active-low ready flag.

Every access starts with a one-byte command written to a command register. The command names the target register and says whether the next transfer reads or writes it. The block holds an 8-bit status register and an 8-bit mode register. It also presents a 24-bit conversion result that the converter core loads from outside. In a streaming read mode, each new result is shifted out as soon as the host clocks, and each result is delivered only once.

All bus pins are sampled in the system clock domain through a short synchronizer. The clock edges of the serial bus are detected as level changes between samples.

Top module: `adc_reg_port`

## Requirements
- R1: After reset, the status register reads 0x8C and the mode register reads 0x02. The data output is released (`dout_oe` low) while select is high.
- R2: The command byte is decoded as follows. Bit 7 must be 0, otherwise the byte is discarded and the next byte is again a command. Bit 6 = 1 selects a read and 0 a write. Bits 5:4 select the register: 00 status, 01 mode, 10 unused (reads 0x00), 11 result (24 bits, read-only). Bit 3 = 1 with a result read enters streaming read. Bits 1:0 become the channel selection on `chan_sel`.
- R3: Every register is shifted most significant bit first. Output bits change after a falling serial-clock edge, and input bits are sampled on the rising edge.
- R4: Status bits read as follows: bit 7 is the ready flag (1 = no unread result), bit 6 is the clamp flag, bits 5:4 are 0, bits 3:2 are 1, and bits 1:0 are the channel from the command that started the read.
- R5: A mode write stores bits 7:6 and 3:1. Bits 5:4 and 0 read back as 0. A write aimed at status, unused or result changes nothing.
- R6: Completing a mode write pulses `pipe_reset` for exactly one clock, sets the ready flag and clears the clamp flag.
- R7: A `result_load` pulse captures `result`, clears the ready flag and copies `result_clamped` into the clamp flag.
- R8: While select is low and no read bit is being driven, `dout` shows the ready flag: 0 when an unread result waits and 1 otherwise.
- R9: Completing a full result read sets the ready flag. A later result read still returns the same value.
- R10: In streaming read, each 24-clock frame starting with ready low returns the current result and then sets ready. Clocks given while ready is high shift out 1s and consume nothing.
- R11: Raising select aborts any partial transfer and leaves streaming read. The next byte after select falls again is a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock, idles high |
| din | input | 1 | Serial data from host |
| dout | output | 1 | Serial read data, or the active-low ready flag |
| dout_oe | output | 1 | Drive enable for `dout` (high while selected) |
| result | input | RES_W | Conversion result from the converter core |
| result_load | input | 1 | One-clock strobe that captures `result` |
| result_clamped | input | 1 | Result was clamped to a rail |
| mode_q | output | 8 | Current mode register |
| chan_sel | output | 2 | Channel selection from the last command |
| pipe_reset | output | 1 | One-clock pulse requesting a conversion restart |

## Verification
The bench covers the following cases:
- **Discarded command bytes.** A design that decodes a command with bit 7 set would take the following byte as data and return the wrong register.
- **Writes to read-only targets.** A design that let such writes through would corrupt status or mode.
- **Reserved mode bits.** A design that stored them would read them back as 1.
- **Aborted transfers.** Select is raised mid-byte; a design that kept its bit count would misalign every later command.
- **Streaming read.** Each result must appear exactly once. A design that re-sent a stale result while ready is high would return data where only 1s belong.
- **Ready interplay.** The bench checks the ready flag across loads, result reads and mode writes, so a wrong priority between them shows up on the idle `dout` level.

// File: rtl/adc_reg_port.sv
module adc_reg_port #(
  parameter int RES_W = 24,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             din,
  output logic             dout,
  output logic             dout_oe,
  input  logic [RES_W-1:0] result,
  input  logic             result_load,
  input  logic             result_clamped,
  output logic [7:0]       mode_q,
  output logic [1:0]       chan_sel,
  output logic             pipe_reset
);
  localparam int CW = $clog2(RES_W);
  localparam int PADW = RES_W - 8;

  typedef enum logic [1:0] {S_COMM, S_WR, S_RD, S_CRD} st_t;
  st_t st;

  logic [SYNC:0]    sck_s;
  logic [SYNC-1:0]  cs_s, din_s;
  logic [RES_W-1:0] sr, data_q;
  logic [CW-1:0]    cnt;
  logic [1:0]       rs_q;
  logic             long_q, rdy, err, drv, dbit;
  logic             cs_act, rise, fall, din_b, last, mode_wr;
  logic [7:0]       cb, status;

  assign cs_act  = ~cs_s[SYNC-1];
  assign rise    = cs_act & sck_s[SYNC-1] & ~sck_s[SYNC];
  assign fall    = cs_act & ~sck_s[SYNC-1] & sck_s[SYNC];
  assign din_b   = din_s[SYNC-1];
  assign cb      = {sr[6:0], din_b};
  assign last    = long_q ? (cnt == CW'(RES_W-1)) : (cnt == CW'(7));
  assign mode_wr = rise && st == S_WR && cnt == CW'(7) && rs_q == 2'b01;
  assign status  = {rdy, err, 4'b0011, cb[1:0]};
  assign dout    = drv ? dbit : rdy;
  assign dout_oe = cs_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s <= '1;
      cs_s  <= '1;
      din_s <= '0;
    end else begin
      sck_s <= {sck_s[SYNC-1:0], sclk};
      cs_s  <= {cs_s[SYNC-2:0], cs_n};
      din_s <= {din_s[SYNC-2:0], din};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_COMM;
      sr         <= '0;
      data_q     <= '0;
      cnt        <= '0;
      rs_q       <= 2'b00;
      long_q     <= 1'b0;
      rdy        <= 1'b1;
      err        <= 1'b0;
      drv        <= 1'b0;
      dbit       <= 1'b1;
      mode_q     <= 8'h02;
      chan_sel   <= 2'b00;
      pipe_reset <= 1'b0;
    end else begin
      pipe_reset <= mode_wr;
      if (!cs_act) begin
        st  <= S_COMM;
        cnt <= '0;
        drv <= 1'b0;
      end else if (fall) begin
        if (st == S_RD || (st == S_CRD && drv)) begin
          dbit <= sr[RES_W-1];
          sr   <= {sr[RES_W-2:0], 1'b0};
          drv  <= 1'b1;
        end else if (st == S_CRD && !rdy) begin
          dbit <= data_q[RES_W-1];
          sr   <= {data_q[RES_W-2:0], 1'b0};
          drv  <= 1'b1;
        end
      end else if (rise) begin
        case (st)
          S_COMM: begin
            cnt <= cnt + CW'(1);
            sr  <= {sr[RES_W-2:0], din_b};
            if (cnt == CW'(7)) begin
              cnt <= '0;
              if (!cb[7]) begin
                chan_sel <= cb[1:0];
                rs_q     <= cb[5:4];
                long_q   <= (cb[5:4] == 2'b11);
                if (cb[6]) begin
                  st <= (cb[5:4] == 2'b11 && cb[3]) ? S_CRD : S_RD;
                  case (cb[5:4])
                    2'b00:   sr <= {status, {PADW{1'b0}}};
                    2'b01:   sr <= {mode_q, {PADW{1'b0}}};
                    2'b10:   sr <= '0;
                    default: sr <= data_q;
                  endcase
                end else begin
                  st <= S_WR;
                end
              end
            end
          end
          S_WR: begin
            cnt <= cnt + CW'(1);
            sr  <= {sr[RES_W-2:0], din_b};
            if (cnt == CW'(7)) begin
              cnt <= '0;
              st  <= S_COMM;
              if (rs_q == 2'b01) begin
                mode_q <= {cb[7:6], 2'b00, cb[3:1], 1'b0};
                rdy    <= 1'b1;
                err    <= 1'b0;
              end
            end
          end
          S_RD: if (drv) begin
            cnt <= cnt + CW'(1);
            if (last) begin
              cnt <= '0;
              drv <= 1'b0;
              st  <= S_COMM;
              if (rs_q == 2'b11) rdy <= 1'b1;
            end
          end
          default: if (drv) begin
            cnt <= cnt + CW'(1);
            if (last) begin
              cnt <= '0;
              drv <= 1'b0;
              rdy <= 1'b1;
            end
          end
        endcase
      end
      if (result_load && !mode_wr) begin
        data_q <= result;
        rdy    <= 1'b0;
        err    <= result_clamped;
      end
    end
  end

  // R6
  mode_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (rdy && !err && pipe_reset));

  // R6
  reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_reset |=> !pipe_reset);

  // R11
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (!drv && st == S_COMM));

  // R7
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (result_load && !mode_wr) |=> (!rdy && data_q == $past(result)));

  // R10
  stream_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CRD && $rose(drv)) |-> $past(!rdy));
endmodule

// File: tb/test_adc_reg_port.sv
module test_adc_reg_port;
  localparam int RW = 24;
  localparam int HP = 5;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b1, din = 1'b0;
  logic result_load = 1'b0, result_clamped = 1'b0;
  logic [RW-1:0] result = '0;
  wire dout, dout_oe, pipe_reset;
  wire [7:0] mode_q;
  wire [1:0] chan_sel;

  int checks = 0, fails = 0, pr_count = 0, cyc = 0;
  logic [7:0] m_mode;
  logic m_rdy, m_err;
  logic [RW-1:0] m_data;

  adc_reg_port #(.RES_W(RW), .SYNC(2)) i_adc_reg_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .dout(dout), .dout_oe(dout_oe), .result(result), .result_load(result_load),
    .result_clamped(result_clamped), .mode_q(mode_q), .chan_sel(chan_sel),
    .pipe_reset(pipe_reset));

  always #10 clk = ~clk;
  always @(posedge clk) begin
    cyc++;
    if (pipe_reset) pr_count++;
  end

  function automatic logic [7:0] exp_stat(logic r, logic e, logic [1:0] ch);
    return {r, e, 4'b0011, ch};
  endfunction
  function automatic logic [7:0] exp_mode(logic [7:0] w);
    return {w[7:6], 2'b00, w[3:1], 1'b0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_x(input logic b, output logic r);
    @(negedge clk); sclk = 1'b0; din = b;
    repeat (HP) @(negedge clk);
    r = dout; sclk = 1'b1;
    repeat (HP) @(negedge clk);
  endtask

  task automatic xfer(input int n, input logic [RW-1:0] tx, output logic [RW-1:0] rx);
    rx = '0;
    for (int i = n - 1; i >= 0; i--) begin
      logic r;
      bit_x(tx[i], r);
      rx[i] = r;
    end
  endtask

  task automatic cs_lo();
    @(negedge clk); cs_n = 1'b0; repeat (4) @(negedge clk);
  endtask
  task automatic cs_hi();
    @(negedge clk); cs_n = 1'b1; repeat (4) @(negedge clk);
  endtask

  task automatic rd8(input logic [7:0] cmd, output logic [7:0] v);
    logic [RW-1:0] rx;
    xfer(8, RW'(cmd), rx);
    xfer(8, '0, rx);
    v = rx[7:0];
  endtask
  task automatic wr8(input logic [7:0] cmd, input logic [7:0] v);
    logic [RW-1:0] rx;
    xfer(8, RW'(cmd), rx);
    xfer(8, RW'(v), rx);
  endtask

  task automatic load(input logic [RW-1:0] v, input logic c);
    @(negedge clk); result = v; result_clamped = c; result_load = 1'b1;
    @(negedge clk); result_load = 1'b0;
    repeat (3) @(negedge clk);
    m_data = v; m_rdy = 1'b0; m_err = c;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    wait (cyc >= 150000);
    checks++; fails++;
    $display("FAIL watchdog (all) actual=%0d expected=<150000 cycles", cyc);
    finish_run();
  end

  initial begin
    logic [7:0] v;
    logic [RW-1:0] rx, junk;
    int prev;
    void'($urandom(32'd1357));
    m_mode = 8'h02; m_rdy = 1'b1; m_err = 1'b0; m_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    chk("R1 oe released", 32'(dout_oe), 0);
    chk("R1 mode port", 32'(mode_q), 32'h02);
    cs_lo();
    chk("R8 idle not ready", 32'(dout), 1);
    rd8(8'h40, v); chk("R1 R4 status reset", 32'(v), 32'h8C);
    rd8(8'h50, v); chk("R1 mode reset", 32'(v), 32'h02);

    for (int k = 0; k < 8; k++) begin
      logic [7:0] w;
      logic [1:0] ch;
      w = 8'($urandom); ch = 2'($urandom);
      prev = pr_count;
      wr8(8'h10 | 8'(ch), w);
      m_mode = exp_mode(w);
      chk("R6 one pulse", 32'(pr_count - prev), 1);
      chk("R2 chan_sel", 32'(chan_sel), 32'(ch));
      rd8(8'h50, v); chk("R5 mode readback", 32'(v), 32'(m_mode));
      ch = 2'($urandom);
      rd8(8'h40 | 8'(ch), v); chk("R4 status fields", 32'(v), 32'(exp_stat(1'b1, 1'b0, ch)));
    end

    wr8(8'h00, 8'hFF);
    rd8(8'h40, v); chk("R5 status write ignored", 32'(v), 32'(exp_stat(1'b1, 1'b0, 2'b00)));
    wr8(8'h30, 8'hFF);
    rd8(8'h50, v); chk("R5 result write ignored", 32'(v), 32'(m_mode));

    xfer(8, RW'(8'hD0), junk);
    rd8(8'h50, v); chk("R2 bit7 command discarded", 32'(v), 32'(m_mode));
    rd8(8'h60, v); chk("R2 unused reads zero", 32'(v), 0);

    load(24'hA5C3_96, 1'b1);
    chk("R8 R7 idle ready low", 32'(dout), 0);
    rd8(8'h41, v); chk("R7 status after load", 32'(v), 32'(exp_stat(1'b0, 1'b1, 2'b01)));
    chk("R8 still ready", 32'(dout), 0);
    xfer(8, RW'(8'h70), junk); xfer(24, '0, rx);
    chk("R3 R9 result read", 32'(rx), 32'(m_data));
    chk("R9 ready set after read", 32'(dout), 1);
    rd8(8'h40, v); chk("R9 status ready", 32'(v), 32'(exp_stat(1'b1, 1'b1, 2'b00)));
    xfer(8, RW'(8'h70), junk); xfer(24, '0, rx);
    chk("R9 reread same", 32'(rx), 32'(m_data));

    load(24'h0F1E2D, 1'b1);
    wr8(8'h10, 8'h42); m_mode = exp_mode(8'h42);
    rd8(8'h40, v); chk("R6 ready set err cleared", 32'(v), 32'(exp_stat(1'b1, 1'b0, 2'b00)));

    begin
      logic r;
      for (int i = 0; i < 4; i++) bit_x(1'b1, r);
    end
    cs_hi();
    chk("R11 released on abort", 32'(dout_oe), 0);
    cs_lo();
    rd8(8'h50, v); chk("R11 realigned command", 32'(v), 32'(m_mode));

    load(RW'($urandom), 1'b0);
    xfer(8, RW'(8'h78), junk);
    xfer(24, '0, rx); chk("R10 stream first", 32'(rx), 32'(m_data));
    xfer(24, '0, rx); chk("R10 no repeat", 32'(rx), 32'hFFFFFF);
    for (int k = 0; k < 4; k++) begin
      load(RW'($urandom), 1'($urandom));
      xfer(24, '0, rx); chk("R10 stream next", 32'(rx), 32'(m_data));
      chk("R10 ready after frame", 32'(dout), 1);
    end
    cs_hi();
    cs_lo();
    rd8(8'h40, v); chk("R11 stream left", 32'(v), 32'(exp_stat(1'b1, m_err, 2'b00)));
    cs_hi();
    chk("R1 released at end", 32'(dout_oe), 0);
    finish_run();
  end
endmodule